// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel

This block is one channel of a DMA engine. It holds a 64-bit descriptor that gives a source address, a destination address, a maximum element count, a transfer type, a trigger number and the address-stepping rules. Once armed, the channel waits for its selected trigger. It then copies bytes or 16-bit words from source to destination over a single-port memory bus. Each element takes two bus cycles: a read, then a write of the returned data.

The channel runs in single, block, repeated-single and repeated-block form. It can also take its element count from the first element it moves, plus a fixed offset, capped at the descriptor length. At completion it pulses a done output, which can chain into the next channel's previous-channel trigger, and an optional interrupt. Arbitration between channels, the trigger sources and the CPU register path are outside the block. The priority field is only decoded and handed to the arbiter.

Top module: `dma_channel`

## Requirements
- R1: The descriptor word `descIn` is latched on `descLoad`. Its fields are: source address [63:48], destination address [47:32], length-mode [31:29], maximum count LEN [28:16], word mode [15], transfer type [14:13] (0 single, 1 block, 2 repeated single, 3 repeated block), trigger number [12:8], source step [7:6], destination step [5:4], interrupt enable [3], variable-length enable [2] and priority [1:0].
- R2: After reset the channel is disarmed, `memReq`, `done` and `irq` are low, and the descriptor is all zeros.
- R3: Trigger number 0 selects `manualReq`, 1 selects `prevDone`, and n from 2 to 31 selects `periphTrig[n]`. A trigger is ignored while the channel is disarmed or while an element is in flight, and lines other than the selected one have no effect.
- R4: A read of the source address at one cycle is followed by a write of the returned data to the destination address at the next cycle. In block types one trigger moves every element back to back.
- R5: In single types each accepted trigger moves exactly one element.
- R6: Step code 0 keeps an address, 1 adds one element, 2 adds two elements and 3 subtracts one element, for source and destination independently.
- R7: In word mode `memWord` is high, a full 16-bit value is moved, and each step is scaled to two bytes. In byte mode the upper data byte is written as zero.
- R8: When variable length is disabled, or the length mode is 0, 5, 6 or 7, the channel moves LEN elements. A count of zero moves one element.
- R9: With variable length enabled, the first element n sets the count, with the length element included: mode 1 gives n+1, mode 2 gives n, mode 3 gives n+2 and mode 4 gives n+3. The count is capped at LEN, never falls below one, and n is the full word in word mode.
- R10: `done` pulses high for one cycle, the cycle after the last write. `irq` pulses with it only when interrupt enable is set.
- R11: On completion the non-repeated types disarm. The repeated types reload both addresses and the count and stay armed.
- R12: `abort` disarms the channel at once and suppresses any bus access in that cycle. The partial transfer is left unfinished and neither `done` nor `irq` is raised.
- R13: `arm` arms the channel and reloads both addresses and the count from the descriptor, so a transfer after re-arming starts at the descriptor base addresses.
- R14: `chanPrio` presents the priority field of the held descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| descLoad | input | 1 | Latch `descIn` as the descriptor |
| descIn | input | 64 | Descriptor word |
| arm | input | 1 | Arm the channel and reload its working state |
| abort | input | 1 | Disarm at once without completion |
| manualReq | input | 1 | Software request, trigger number 0 |
| prevDone | input | 1 | Previous channel completed, trigger number 1 |
| periphTrig | input | 30 | Peripheral trigger lines 31 down to 2 |
| memReq | output | 1 | Bus access this cycle |
| memWe | output | 1 | Access is a write |
| memWord | output | 1 | Access is 16 bits wide |
| memAddr | output | 16 | Byte address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid the cycle after a read |
| armed | output | 1 | Channel armed |
| done | output | 1 | Transfer complete pulse |
| irq | output | 1 | Completion interrupt pulse |
| chanPrio | output | 2 | Decoded priority for the arbiter |

## Verification
The main transfer runs over a table of descriptors in block form. The table varies the step codes, the element width and every length mode, with the first element chosen so that modes 1 to 4 produce four distinct counts. One entry exceeds the cap, and one word-mode entry would give a different count if only the low byte were used. Every logged write is compared against the address and data predicted for its position. An entry with variable length disabled, and one with a reserved mode, check that the first element's value is not used for the count. Directed runs separate single from block operation and repeated from one-shot completion, show that only the selected trigger line acts and that triggers to a disarmed channel are dropped, and check that abort leaves a partial transfer with no completion.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 16;
  localparam int DESC_W     = 4 * ADDR_W;
  localparam int LEN_W      = 13;
  localparam int TRIG_SEL_W = 5;
  localparam int NUM_TRIG   = 1 << TRIG_SEL_W;

  typedef enum logic [1:0] {
    XFER_SINGLE     = 2'd0,
    XFER_BLOCK      = 2'd1,
    XFER_RPT_SINGLE = 2'd2,
    XFER_RPT_BLOCK  = 2'd3
  } xferType_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } chState_e;

  // Control to datapath strobes
  typedef struct packed {
    logic reload;
    logic wrStb;
  } dpStrobe_t;
endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              descLoad,
  input  logic [DESC_W-1:0] descIn,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wordMode,
  output xferType_e         xferType,
  output logic [TRIG_SEL_W-1:0] trigSel,
  output logic              irqEn,
  output logic [1:0]        prio,
  output logic              lastElem
);
  logic [DESC_W-1:0] descQ;
  logic [ADDR_W-1:0] srcBase, dstBase;
  logic [2:0]        vlenMode;
  logic [LEN_W-1:0]  maxLen;
  logic [1:0]        srcStep, dstStep;
  logic              vlenEn, isVar;
  logic [1:0]        vlenOff;
  logic [DATA_W-1:0] lenElem;
  logic [ADDR_W:0]   sumLen;
  logic [ADDR_W-1:0] capLen, effTarget;
  logic [ADDR_W-1:0] movedQ, targetQ;
  logic [ADDR_W:0]   movedNext;
  logic              firstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         descQ <= '0;
    else if (descLoad) descQ <= descIn;
  end

  // Field decode (positions fixed by the descriptor layout)
  assign srcBase  = descQ[63:48];
  assign dstBase  = descQ[47:32];
  assign vlenMode = descQ[31:29];
  assign maxLen   = descQ[28:16];
  assign wordMode = descQ[15];
  assign xferType = xferType_e'(descQ[14:13]);
  assign trigSel  = descQ[12:8];
  assign srcStep  = descQ[7:6];
  assign dstStep  = descQ[5:4];
  assign irqEn    = descQ[3];
  assign vlenEn   = descQ[2];
  assign prio     = descQ[1:0];

  function automatic logic [ADDR_W-1:0] stepAmt(input logic [1:0] code, input logic word);
    logic [ADDR_W-1:0] elemSz;
    elemSz = word ? ADDR_W'(2) : ADDR_W'(1);
    case (code)
      2'd0:    stepAmt = '0;
      2'd1:    stepAmt = elemSz;
      2'd2:    stepAmt = elemSz << 1;
      default: stepAmt = ~elemSz + ADDR_W'(1);
    endcase
  endfunction

  // Variable length: count from the first element plus an offset
  assign isVar = vlenEn && (vlenMode >= 3'd1) && (vlenMode <= 3'd4);
  always_comb begin
    case (vlenMode)
      3'd1:    vlenOff = 2'd1;
      3'd3:    vlenOff = 2'd2;
      3'd4:    vlenOff = 2'd3;
      default: vlenOff = 2'd0;
    endcase
  end

  assign lenElem   = wordMode ? memRdata : {8'h00, memRdata[7:0]};
  assign sumLen    = {1'b0, lenElem} + (ADDR_W+1)'(vlenOff);
  assign capLen    = (sumLen > (ADDR_W+1)'(maxLen)) ? ADDR_W'(maxLen) : sumLen[ADDR_W-1:0];
  assign effTarget = (firstQ && isVar) ? capLen : targetQ;
  assign movedNext = {1'b0, movedQ} + (ADDR_W+1)'(1);
  assign lastElem  = movedNext >= {1'b0, effTarget};
  assign wrData    = lenElem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      movedQ  <= '0;
      targetQ <= '0;
      firstQ  <= 1'b1;
    end else if (stb.reload) begin
      srcAddr <= srcBase;
      dstAddr <= dstBase;
      movedQ  <= '0;
      targetQ <= ADDR_W'(maxLen);
      firstQ  <= 1'b1;
    end else if (stb.wrStb) begin
      srcAddr <= srcAddr + stepAmt(srcStep, wordMode);
      dstAddr <= dstAddr + stepAmt(dstStep, wordMode);
      movedQ  <= movedNext[ADDR_W-1:0];
      targetQ <= effTarget;
      firstQ  <= 1'b0;
    end
  end

  // R7
  word_align_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && !stb.reload && wordMode && !descLoad)
      |=> (srcAddr[0] == $past(srcAddr[0]) && dstAddr[0] == $past(dstAddr[0])));

  // R13
  reload_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.reload && !descLoad) |=> (srcAddr == srcBase && dstAddr == dstBase));
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  arm,
  input  logic                  abort,
  input  logic                  manualReq,
  input  logic                  prevDone,
  input  logic [NUM_TRIG-1:2]   periphTrig,
  input  logic [TRIG_SEL_W-1:0] trigSel,
  input  xferType_e             xferType,
  input  logic                  irqEn,
  input  logic                  lastElem,
  output dpStrobe_t             stb,
  output logic                  memReq,
  output logic                  memWe,
  output logic                  armed,
  output logic                  done,
  output logic                  irq
);
  chState_e           state, nextState;
  logic               nextArmed, finish, trigHit;
  logic [NUM_TRIG-1:0] trigAll;
  logic               isBlock, isRepeat, busIdleCut;

  assign trigAll  = {periphTrig, prevDone, manualReq};
  assign trigHit  = trigAll[trigSel];
  assign isBlock  = (xferType == XFER_BLOCK) || (xferType == XFER_RPT_BLOCK);
  assign isRepeat = (xferType == XFER_RPT_SINGLE) || (xferType == XFER_RPT_BLOCK);
  assign busIdleCut = abort || arm;

  always_comb begin
    stb       = '0;
    nextState = state;
    nextArmed = armed;
    finish    = 1'b0;
    if (abort) begin
      nextState = ST_IDLE;
      nextArmed = 1'b0;
    end else if (arm) begin
      nextState  = ST_IDLE;
      nextArmed  = 1'b1;
      stb.reload = 1'b1;
    end else begin
      case (state)
        ST_IDLE:  if (armed && trigHit) nextState = ST_READ;
        ST_READ:  nextState = ST_WRITE;
        ST_WRITE: begin
          stb.wrStb = 1'b1;
          if (lastElem) begin
            finish    = 1'b1;
            nextState = ST_IDLE;
            if (isRepeat) stb.reload = 1'b1;
            else          nextArmed  = 1'b0;
          end else begin
            nextState = isBlock ? ST_READ : ST_IDLE;
          end
        end
        default:  nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      armed <= 1'b0;
      done  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      state <= nextState;
      armed <= nextArmed;
      done  <= finish;
      irq   <= finish && irqEn;
    end
  end

  assign memReq = ((state == ST_READ) || (state == ST_WRITE)) && !busIdleCut;
  assign memWe  = (state == ST_WRITE) && !busIdleCut;

  // R12
  abort_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!armed && !memReq));

  // R3
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !memReq);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> done);

  // R11
  rpt_stay_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && lastElem && isRepeat) |=> armed);
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                descLoad,
  input  logic [DESC_W-1:0]   descIn,
  input  logic                arm,
  input  logic                abort,
  input  logic                manualReq,
  input  logic                prevDone,
  input  logic [NUM_TRIG-1:2] periphTrig,
  output logic                memReq,
  output logic                memWe,
  output logic                memWord,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                armed,
  output logic                done,
  output logic                irq,
  output logic [1:0]          chanPrio
);
  dpStrobe_t             stb;
  logic [ADDR_W-1:0]     srcAddr, dstAddr;
  logic                  wordMode, irqEn, lastElem;
  xferType_e             xferType;
  logic [TRIG_SEL_W-1:0] trigSel;

  dma_datapath uDp (
    .clk(clk), .rstN(rstN), .descLoad(descLoad), .descIn(descIn),
    .stb(stb), .memRdata(memRdata), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .wrData(memWdata), .wordMode(wordMode), .xferType(xferType),
    .trigSel(trigSel), .irqEn(irqEn), .prio(chanPrio), .lastElem(lastElem)
  );

  dma_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .arm(arm), .abort(abort), .manualReq(manualReq),
    .prevDone(prevDone), .periphTrig(periphTrig), .trigSel(trigSel),
    .xferType(xferType), .irqEn(irqEn), .lastElem(lastElem), .stb(stb),
    .memReq(memReq), .memWe(memWe), .armed(armed), .done(done), .irq(irq)
  );

  assign memWord = wordMode;
  assign memAddr = memWe ? dstAddr : srcAddr;
endmodule

// File: tb/tb_dma_channel.sv
`timescale 1ns/100ps
module tb_dma_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        descLoad = 1'b0;
  logic [63:0] descIn = '0;
  logic        arm = 1'b0, abort = 1'b0, manualReq = 1'b0, prevDone = 1'b0;
  logic [31:2] periphTrig = '0;
  logic        memReq, memWe, memWord, armed, done, irq;
  logic [15:0] memAddr, memWdata;
  logic [15:0] memRdata = '0;
  logic [1:0]  chanPrio;

  always #2.5 clk = ~clk;

  dma_channel dut (
    .clk(clk), .rstN(rstN), .descLoad(descLoad), .descIn(descIn), .arm(arm),
    .abort(abort), .manualReq(manualReq), .prevDone(prevDone),
    .periphTrig(periphTrig), .memReq(memReq), .memWe(memWe), .memWord(memWord),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .armed(armed),
    .done(done), .irq(irq), .chanPrio(chanPrio)
  );

  // Memory model and write log
  logic [7:0]  mem [256];
  logic [15:0] logAddr [64];
  logic [15:0] logData [64];
  int          wrCnt = 0, doneCnt = 0, irqCnt = 0;
  logic        memInit = 1'b0;
  logic [15:0] curFirst = '0;
  logic        curWord = 1'b0;
  localparam logic [15:0] SRC_BASE = 16'h0010;

  function automatic logic [7:0] origB(input logic [7:0] a);
    if (a == SRC_BASE[7:0]) return curFirst[7:0];
    if (curWord && a == SRC_BASE[7:0] + 8'd1) return curFirst[15:8];
    return a ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (memInit) begin
      for (int i = 0; i < 256; i++) mem[i] <= origB(8'(i));
      wrCnt <= 0; doneCnt <= 0; irqCnt <= 0;
    end else begin
      if (memReq && !memWe)
        memRdata <= memWord ? {mem[8'(memAddr[7:0] + 8'd1)], mem[memAddr[7:0]]}
                            : {8'h00, mem[memAddr[7:0]]};
      if (memReq && memWe) begin
        mem[memAddr[7:0]] <= memWdata[7:0];
        if (memWord) mem[8'(memAddr[7:0] + 8'd1)] <= memWdata[15:8];
        logAddr[wrCnt[5:0]] <= memAddr;
        logData[wrCnt[5:0]] <= memWdata;
        wrCnt <= wrCnt + 1;
      end
      if (done) doneCnt <= doneCnt + 1;
      if (irq)  irqCnt  <= irqCnt + 1;
    end
  end

  int errors = 0, checks = 0;
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] mkDesc(
    input logic [15:0] src, input logic [15:0] dst, input logic [2:0] vmode,
    input logic [12:0] len, input logic word, input logic [1:0] xtype,
    input logic [4:0] trig, input logic [1:0] sStep, input logic [1:0] dStep,
    input logic irqE, input logic vEn, input logic [1:0] pr);
    return {src, dst, vmode, len, word, xtype, trig, sStep, dStep, irqE, vEn, pr};
  endfunction

  task automatic setup(input logic [63:0] d, input logic [15:0] first, input logic word);
    @(negedge clk);
    curFirst = first; curWord = word;
    memInit = 1'b1; descLoad = 1'b1; descIn = d;
    @(negedge clk);
    memInit = 1'b0; descLoad = 1'b0;
  endtask

  task automatic pulseArm;   arm = 1'b1; @(negedge clk); arm = 1'b0; endtask
  task automatic pulseAbort; abort = 1'b1; @(negedge clk); abort = 1'b0; endtask
  task automatic pulseManual; manualReq = 1'b1; @(negedge clk); manualReq = 1'b0; endtask
  task automatic pulsePrev;  prevDone = 1'b1; @(negedge clk); prevDone = 1'b0; endtask
  task automatic pulsePeriph(input int n);
    periphTrig[n] = 1'b1; @(negedge clk); periphTrig[n] = 1'b0;
  endtask

  task automatic waitDone;
    for (int c = 0; c < 400 && doneCnt == 0; c++) @(negedge clk);
    tick(2);
  endtask

  function automatic int stepB(input logic [1:0] code, input logic word);
    int e;
    e = word ? 2 : 1;
    case (code)
      2'd0: return 0;
      2'd1: return e;
      2'd2: return 2 * e;
      default: return -e;
    endcase
  endfunction

  typedef struct packed {
    logic [2:0]  vmode;
    logic        vEn;
    logic        word;
    logic [1:0]  sStep;
    logic [1:0]  dStep;
    logic [12:0] len;
    logic [15:0] first;
    logic [15:0] dstBase;
    logic [7:0]  expCnt;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b0, 2'd1, 2'd1, 13'd5,  16'h0000, 16'h0080, 8'd5},
    '{3'd0, 1'b0, 1'b1, 2'd1, 2'd1, 13'd3,  16'h0000, 16'h0080, 8'd3},
    '{3'd0, 1'b0, 1'b0, 2'd2, 2'd3, 13'd4,  16'h0000, 16'h00F0, 8'd4},
    '{3'd1, 1'b1, 1'b0, 2'd1, 2'd1, 13'd20, 16'h0003, 16'h0080, 8'd4},
    '{3'd2, 1'b1, 1'b0, 2'd1, 2'd1, 13'd20, 16'h0003, 16'h0080, 8'd3},
    '{3'd3, 1'b1, 1'b0, 2'd1, 2'd1, 13'd20, 16'h0003, 16'h0080, 8'd5},
    '{3'd4, 1'b1, 1'b0, 2'd1, 2'd1, 13'd20, 16'h0003, 16'h0080, 8'd6},
    '{3'd1, 1'b1, 1'b0, 2'd1, 2'd1, 13'd6,  16'h001E, 16'h0080, 8'd6},
    '{3'd5, 1'b1, 1'b0, 2'd1, 2'd1, 13'd4,  16'h0002, 16'h0080, 8'd4},
    '{3'd1, 1'b0, 1'b0, 2'd1, 2'd1, 13'd4,  16'h0001, 16'h0080, 8'd4},
    '{3'd2, 1'b1, 1'b1, 2'd1, 2'd1, 13'd10, 16'h0104, 16'h0080, 8'd10},
    '{3'd0, 1'b0, 1'b0, 2'd0, 2'd1, 13'd3,  16'h0000, 16'h0080, 8'd3},
    '{3'd0, 1'b0, 1'b0, 2'd1, 2'd1, 13'd0,  16'h0000, 16'h0080, 8'd1},
    '{3'd2, 1'b1, 1'b0, 2'd1, 2'd1, 13'd9,  16'h0000, 16'h0080, 8'd1}
  };

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R2 reset state
    check(!armed && !memReq && !done && !irq, "R2 reset outputs",
          {armed, memReq, done, irq}, 0);
    rstN = 1'b1;
    tick(2);

    // Table: block transfers, manual trigger, R1 R4 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int bad;
      t = VECS[v];
      setup(mkDesc(SRC_BASE, t.dstBase, t.vmode, t.len, t.word, 2'd1, 5'd0,
                   t.sStep, t.dStep, 1'b1, t.vEn, 2'd0), t.first, t.word);
      pulseArm();
      pulseManual();
      waitDone();
      check(wrCnt == int'(t.expCnt), (t.vEn ? "R9 count" : "R8 count"), wrCnt, t.expCnt);
      bad = 0;
      for (int k = 0; k < int'(t.expCnt) && k < 64; k++) begin
        logic [15:0] sa, da, ed;
        sa = 16'(int'(SRC_BASE) + k * stepB(t.sStep, t.word));
        da = 16'(int'(t.dstBase) + k * stepB(t.dStep, t.word));
        ed = t.word ? {origB(8'(sa[7:0] + 8'd1)), origB(sa[7:0])} : {8'h00, origB(sa[7:0])};
        if (logAddr[k] != da || logData[k] != ed) bad++;
      end
      check(bad == 0, "R1 R4 R6 R7 addr/data per element", bad, 0);
      check(doneCnt == 1 && irqCnt == 1 && !armed, "R10 R11 completion", {doneCnt, irqCnt, armed}, 2);
    end

    // R3: disarmed channel ignores its trigger
    setup(mkDesc(SRC_BASE, 16'h0080, 3'd0, 13'd2, 1'b0, 2'd1, 5'd0, 2'd1, 2'd1, 1'b1, 1'b0, 2'd0), 16'h0, 1'b0);
    pulseManual(); tick(6);
    check(wrCnt == 0 && !armed, "R3 disarmed trigger ignored", wrCnt, 0);

    // R3 R5: single type on peripheral line 5
    setup(mkDesc(SRC_BASE, 16'h0080, 3'd0, 13'd3, 1'b0, 2'd0, 5'd5, 2'd1, 2'd1, 1'b1, 1'b0, 2'd0), 16'h0, 1'b0);
    pulseArm();
    pulsePeriph(6); pulseManual(); tick(6);
    check(wrCnt == 0, "R3 other line ignored", wrCnt, 0);
    pulsePeriph(5); tick(6);
    check(wrCnt == 1 && armed && doneCnt == 0, "R5 one element per trigger", wrCnt, 1);
    pulsePeriph(5); tick(6);
    pulsePeriph(5); tick(6);
    check(wrCnt == 3 && doneCnt == 1 && !armed, "R5 R11 single completes and disarms", wrCnt, 3);

    // R11 R3: repeated single on previous-channel trigger
    setup(mkDesc(SRC_BASE, 16'h0080, 3'd0, 13'd2, 1'b0, 2'd2, 5'd1, 2'd1, 2'd1, 1'b1, 1'b0, 2'd0), 16'h0, 1'b0);
    pulseArm();
    pulsePrev(); tick(6);
    pulsePrev(); tick(6);
    check(doneCnt == 1 && armed, "R11 repeated single stays armed", {doneCnt, armed}, 3);
    pulsePrev(); tick(6);
    check(wrCnt == 3 && logAddr[2] == 16'h0080, "R11 addresses reloaded", logAddr[2], 16'h0080);

    // R10 R11: repeated block on line 31, interrupt disabled
    setup(mkDesc(SRC_BASE, 16'h0080, 3'd0, 13'd2, 1'b0, 2'd3, 5'd31, 2'd1, 2'd1, 1'b0, 1'b0, 2'd2), 16'h0, 1'b0);
    pulseArm();
    pulsePeriph(31); tick(8);
    check(wrCnt == 2 && doneCnt == 1 && irqCnt == 0 && armed, "R10 done without irq", irqCnt, 0);
    pulsePeriph(31); tick(8);
    check(wrCnt == 4 && logAddr[2] == 16'h0080, "R11 repeated block reload", logAddr[2], 16'h0080);
    // R14
    check(chanPrio == 2'd2, "R14 priority field", chanPrio, 2);

    // R12: abort mid-block
    setup(mkDesc(SRC_BASE, 16'h0080, 3'd0, 13'd20, 1'b0, 2'd1, 5'd0, 2'd1, 2'd1, 1'b1, 1'b0, 2'd0), 16'h0, 1'b0);
    pulseArm();
    pulseManual(); tick(3);
    pulseAbort(); tick(10);
    check(!armed && wrCnt > 0 && wrCnt < 20 && doneCnt == 0 && irqCnt == 0,
          "R12 abort partial no completion", wrCnt, 1);
    begin
      int w;
      w = wrCnt;
      pulseManual(); tick(10);
      check(wrCnt == w, "R12 aborted channel stays idle", wrCnt, w);
    end

    // R13: re-arm restarts from descriptor bases
    setup(mkDesc(SRC_BASE, 16'h0080, 3'd0, 13'd20, 1'b0, 2'd1, 5'd0, 2'd1, 2'd1, 1'b1, 1'b0, 2'd0), 16'h0, 1'b0);
    pulseArm();
    pulseManual();
    waitDone();
    check(wrCnt == 20 && logAddr[0] == 16'h0080 && logData[0] == {8'h00, origB(8'h10)},
          "R13 re-arm reload", logAddr[0], 16'h0080);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule